// File: doc/BRIEF.md
# Auto-Detecting Host Bus Front End

This block lets a host processor read and write an internal register file over either a bus with separate address and data lines or a bus that carries address and data on the same wires. A static mode pin, `mux_sel`, chooses between the two. On the shared bus, the address is taken from the data wires when the address-latch line falls. At that same moment the block samples the level of the strobe line. That level decides, for this transfer only, how the strobe and direction lines are read.

The bus is asynchronous to the block clock. Every control line passes through a two-flop synchroniser. The block then issues a one-clock read-enable or write-enable pulse toward the register file, with an address and write data that stay registered. It also drives read data back toward the pads through an output-enable, which the pad ring uses to control the tristate driver. Ready is always immediate, so the block has no wait-state logic.

Top module: `hbus_front`

## Requirements
- R1: While `rst_n` is low, `reg_re`, `reg_we` and `bus_oe` are 0, and `reg_addr`, `reg_wdata` and `bus_out` are all zero.
- R2: With `mux_sel`=0, a transfer is active while `cs_n` is 0 and `strb` is 1. `dirn`=1 means read and `dirn`=0 means write. The address is taken from `addr_in` and `addr_latch` has no effect.
- R3: With `mux_sel`=1, `reg_addr` takes `bus_in[AW-1:0]` three clocks after `addr_latch` falls. It holds that value until the next such fall, and `addr_in` has no effect.
- R4: With `mux_sel`=1, the level of `strb` when `addr_latch` falls selects the convention for that transfer, and this choice is made again on every transfer.
  - Level 1 selects the split-strobe convention. `strb`=0 is a read and `dirn`=0 is a write.
  - Level 0 selects the qualified-strobe convention. `strb`=1 is active and `dirn` gives the direction (1 = read).
- R5: Each activation of a strobe gives exactly one pulse, on `reg_re` for a read or on `reg_we` for a write. The pulse comes three clocks after the bus edge and never comes on both outputs at once. Holding the strobe gives no further pulses.
- R6: A write pulse is given with `reg_wdata` equal to `bus_in` as sampled on the clock edge that raises the pulse.
- R7: `bus_oe` is 1 only while a read strobe is seen as active with chip select asserted. It rises together with `reg_re`. `bus_out` carries the read data from the next clock on.
- R8: Strobes give no pulse and no `bus_oe` while `cs_n` is 1. With `mux_sel`=1, they also give none while `addr_latch` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_sel | input | 1 | Static bus type: 0 separate address, 1 shared address/data |
| cs_n | input | 1 | Active-low chip select |
| addr_latch | input | 1 | Address latch strobe, shared-bus mode only |
| strb | input | 1 | Data strobe / read strobe line |
| dirn | input | 1 | Direction / write strobe line |
| addr_in | input | AW | Address lines, separate-address mode |
| bus_in | input | DW | Data (and, shared mode, address) from the pads |
| bus_out | output | DW | Read data toward the pads |
| bus_oe | output | 1 | Pad driver enable for `bus_out` |
| reg_addr | output | AW | Register file address |
| reg_wdata | output | DW | Register file write data |
| reg_we | output | 1 | One-clock write enable |
| reg_re | output | 1 | One-clock read enable |
| reg_rdata | input | DW | Register file read data for `reg_addr` |

## Verification
The fall of `addr_latch` and the evaluation of the strobe decoder can land in the same clock. The convention decided at that fall must already govern the decoder in that clock. Otherwise the `strb` level that selects the new convention would look like an active strobe under the old one.

The bench provokes this with chip select held low through back-to-back transfers that alternate between the two conventions. Each `strb` level is therefore the opposite of the previous transfer's idle level. The result is judged from the pulse counts: exactly one pulse per transfer. It is also judged against the every-clock reference model for address, data and output-enable.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef struct packed {
    logic act;  // a strobe is currently active
    logic rd;   // the active transfer is a read
  } strobe_t;

  // Interpret the synchronised bus lines for the current convention.
  // split_conv = 1: strb low = read, dirn low = write.
  // split_conv = 0: strb high = strobe, dirn level = direction.
  function automatic strobe_t decode_strobe(input logic shared_bus, input logic split_conv,
                                            input logic cs_n, input logic alat,
                                            input logic strb, input logic dirn);
    strobe_t s;
    s.act = 1'b0;
    s.rd  = 1'b0;
    if (!cs_n) begin
      if (!shared_bus) begin
        s.act = strb;
        s.rd  = dirn;
      end else if (!alat) begin
        if (split_conv) begin
          s.rd  = !strb;
          s.act = !strb || !dirn;
        end else begin
          s.act = strb;
          s.rd  = dirn;
        end
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int             W       = 4,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hbus_detect.sv
module hbus_detect
  import hbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mux_sel,
  input  logic s_cs_n,
  input  logic s_alat,
  input  logic s_strb,
  input  logic s_dirn,
  output logic alat_fall,
  output logic rise,
  output logic rise_rd,
  output logic hold_rd
);
  logic    alat_q, split_q, act_q, split_now;
  strobe_t st;

  assign alat_fall = mux_sel & alat_q & ~s_alat;
  // a new convention is valid in the very clock of the latch fall
  assign split_now = alat_fall ? s_strb : split_q;
  assign st        = decode_strobe(mux_sel, split_now, s_cs_n, s_alat, s_strb, s_dirn);
  assign rise      = st.act & ~act_q;
  assign rise_rd   = st.rd;
  assign hold_rd   = st.act & st.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alat_q  <= 1'b0;
      split_q <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      alat_q  <= s_alat;
      split_q <= split_now;
      act_q   <= st.act;
    end
  end

  // R4: convention changes only after a latch fall
  p_conv_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(split_q) |-> $past(alat_fall));
endmodule

// File: rtl/hbus_front.sv
module hbus_front #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux_sel,
  input  logic          cs_n,
  input  logic          addr_latch,
  input  logic          strb,
  input  logic          dirn,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  localparam int NSTRB = 4;
  localparam int CAPW  = (AW < DW) ? AW : DW;
  localparam logic [NSTRB-1:0] IDLE = 4'b1011;  // cs_n, latch, strb, dirn

  logic [NSTRB-1:0] raw_lines, syn_lines;
  logic s_cs_n, s_alat, s_strb, s_dirn;
  logic alat_fall, rise, rise_rd, hold_rd;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic re_q, we_q, oe_q;

  assign raw_lines = {cs_n, addr_latch, strb, dirn};
  assign {s_cs_n, s_alat, s_strb, s_dirn} = syn_lines;

  hbus_sync #(.W(NSTRB), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(syn_lines));

  hbus_detect u_detect (
    .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel),
    .s_cs_n(s_cs_n), .s_alat(s_alat), .s_strb(s_strb), .s_dirn(s_dirn),
    .alat_fall(alat_fall), .rise(rise), .rise_rd(rise_rd), .hold_rd(hold_rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      re_q    <= 1'b0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (mux_sel && alat_fall)   addr_q <= AW'(bus_in[CAPW-1:0]);
      else if (!mux_sel && rise)  addr_q <= addr_in;
      if (rise && !rise_rd)       wdata_q <= bus_in;
      if (re_q)                   rdata_q <= reg_rdata;
      re_q <= rise & rise_rd;
      we_q <= rise & ~rise_rd;
      oe_q <= hold_rd;
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_re    = re_q;
  assign reg_we    = we_q;
  assign bus_oe    = oe_q;
  assign bus_out   = rdata_q;

  // R5: pulses last one clock and never coincide
  p_single_re_r5: assert property (@(posedge clk) disable iff (!rst_n) reg_re |=> !reg_re);
  p_single_we_r5: assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we);
  p_excl_rw_r5:   assert property (@(posedge clk) disable iff (!rst_n) !(reg_re && reg_we));
  // R7: a read pulse always comes with the driver enabled
  p_read_oe_r7:   assert property (@(posedge clk) disable iff (!rst_n) reg_re |-> bus_oe);
  // R8: driver never enabled without a synchronised chip select
  p_oe_cs_r8:     assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> !$past(s_cs_n));
  // R3: shared-bus address moves only after a latch fall
  p_mux_addr_r3:  assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel && $past(mux_sel) && !$stable(reg_addr)) |-> $past(alat_fall));
  // R2: separate-bus address moves only with a pulse
  p_nm_addr_r2:   assert property (@(posedge clk) disable iff (!rst_n)
    (!mux_sel && $past(!mux_sel) && !$stable(reg_addr)) |-> (reg_re || reg_we));
endmodule

// File: tb/hbus_front_bench.sv
`timescale 1ns/1ps
module hbus_front_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mux_sel = 1'b0, cs_n = 1'b1, alat = 1'b0, strb = 1'b0, dirn = 1'b1;
  logic [7:0] addr_in = '0, bus_in = '0;
  logic [7:0] bus_out, reg_addr, reg_wdata, reg_rdata;
  logic bus_oe, reg_we, reg_re;
  logic [7:0] mem [0:255];
  int n_chk = 0, n_fail = 0, n_re = 0, n_we = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hbus_front u_hbus_front (
    .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .cs_n(cs_n), .addr_latch(alat),
    .strb(strb), .dirn(dirn), .addr_in(addr_in), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (reg_we) mem[reg_addr] <= reg_wdata;
  end

  always @(posedge clk) if (rst_n) begin
    if (reg_re) n_re++;
    if (reg_we) n_we++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: line history and expected outputs
  logic [3:0] h_new, h_vis;
  logic h_lat_prev, h_split, h_act_prev;
  logic e_re, e_we, e_oe;
  logic [7:0] e_addr, e_wdata, e_rdata;
  always @(posedge clk) begin
    if (!rst_n) begin
      h_new = 4'b1011; h_vis = 4'b1011;
      h_lat_prev = 0; h_split = 0; h_act_prev = 0;
      e_re = 0; e_we = 0; e_oe = 0; e_addr = 0; e_wdata = 0; e_rdata = 0;
    end else begin
      bit fell, conv, a, r, go;
      fell = mux_sel && h_lat_prev && !h_vis[2];
      conv = fell ? h_vis[1] : h_split;
      a = 0; r = 0;
      if (h_vis[3] == 1'b0) begin
        case ({mux_sel, h_vis[2], conv})
          3'b000, 3'b001, 3'b010, 3'b011: begin a = h_vis[1]; r = h_vis[0]; end
          3'b100: begin a = h_vis[1]; r = h_vis[0]; end
          3'b101: begin r = ~h_vis[1]; a = r | ~h_vis[0]; end
          default: ;
        endcase
      end
      if (e_re) e_rdata = mem[e_addr];
      go = a && !h_act_prev;
      if (mux_sel && fell) e_addr = bus_in;
      else if (!mux_sel && go) e_addr = addr_in;
      if (go && !r) e_wdata = bus_in;
      e_re = go && r; e_we = go && !r; e_oe = a && r;
      h_act_prev = a; h_split = conv; h_lat_prev = h_vis[2];
      h_vis = h_new; h_new = {cs_n, alat, strb, dirn};
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(reg_re === e_re,       "R5 reg_re",    32'(reg_re),    32'(e_re));
    chk(reg_we === e_we,       "R5 reg_we",    32'(reg_we),    32'(e_we));
    chk(reg_addr === e_addr,   "R3 reg_addr",  32'(reg_addr),  32'(e_addr));
    chk(reg_wdata === e_wdata, "R6 reg_wdata", 32'(reg_wdata), 32'(e_wdata));
    chk(bus_oe === e_oe,       "R7 bus_oe",    32'(bus_oe),    32'(e_oe));
    chk(bus_out === e_rdata,   "R7 bus_out",   32'(bus_out),   32'(e_rdata));
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic nm_write(input logic [7:0] a, input logic [7:0] d);
    int w0;
    w0 = n_we;
    addr_in = a; bus_in = d; dirn = 0; cs_n = 0; wait_n(1);
    strb = 1; wait_n(6);
    strb = 0; cs_n = 1; dirn = 1; wait_n(3);
    chk(mem[a] === d, "R2 separate-bus write", 32'(mem[a]), 32'(d));
    chk(n_we - w0 == 1, "R5 one write pulse", 32'(n_we - w0), 1);
  endtask

  task automatic nm_read(input logic [7:0] a, input logic [7:0] exp);
    int r0;
    r0 = n_re;
    addr_in = a; dirn = 1; cs_n = 0; wait_n(1);
    strb = 1; wait_n(6);
    chk(bus_oe === 1'b1, "R7 oe during read", 32'(bus_oe), 1);
    chk(bus_out === exp, "R2 separate-bus read", 32'(bus_out), 32'(exp));
    strb = 0; cs_n = 1; wait_n(4);
    chk(bus_oe === 1'b0, "R7 oe released", 32'(bus_oe), 0);
    chk(n_re - r0 == 1, "R5 one read pulse", 32'(n_re - r0), 1);
  endtask

  // shared-bus transfer; cs_n is controlled by the caller
  task automatic mx_cycle(input bit split, input bit wr, input logic [7:0] a,
                          input logic [7:0] d, input logic [7:0] exp, input bit expect_pulse);
    int p0;
    p0 = n_re + n_we;
    alat = 1; bus_in = a; strb = split; dirn = split ? 1'b1 : !wr;
    addr_in = ~a; wait_n(4);
    alat = 0; wait_n(4);
    bus_in = wr ? d : 8'h00; wait_n(1);
    if (split) begin
      if (wr) dirn = 0; else strb = 0;
    end else strb = 1;
    wait_n(6);
    if (expect_pulse && !wr) begin
      chk(bus_oe === 1'b1, "R4 oe in shared read", 32'(bus_oe), 1);
      chk(bus_out === exp, "R4 shared read data", 32'(bus_out), 32'(exp));
      chk(reg_addr === a, "R3 latched address", 32'(reg_addr), 32'(a));
    end
    if (split) begin strb = 1; dirn = 1; end else strb = 0;
    wait_n(5);
    chk((n_re + n_we - p0) == (expect_pulse ? 1 : 0), "R5 pulses per transfer",
        32'(n_re + n_we - p0), expect_pulse ? 1 : 0);
  endtask

  initial begin
    int p0;
    wait_n(2);
    chk(reg_re === 0 && reg_we === 0 && bus_oe === 0, "R1 reset strobes",
        32'({reg_re, reg_we, bus_oe}), 0);
    chk(reg_addr === 0 && reg_wdata === 0 && bus_out === 0, "R1 reset data",
        32'(reg_addr | reg_wdata | bus_out), 0);
    wait_n(2);
    rst_n = 1; wait_n(3);

    nm_write(8'h10, 8'h3C);
    nm_write(8'hFF, 8'h81);
    nm_read(8'h10, 8'h3C);
    nm_read(8'hFF, 8'h81);
    nm_read(8'h05, 8'hA0);

    // R8: strobes without chip select
    p0 = n_re + n_we;
    repeat (3) begin strb = 1; dirn = 0; wait_n(5); strb = 0; dirn = 1; wait_n(5); end
    chk(n_re + n_we == p0, "R8 no pulse without cs", 32'(n_re + n_we - p0), 0);
    chk(bus_oe === 0, "R8 no oe without cs", 32'(bus_oe), 0);

    // R2: latch line ignored on the separate bus
    alat = 1; wait_n(3); alat = 0;
    nm_read(8'h33, 8'h96);

    // shared bus, back-to-back with cs held low, alternating conventions
    strb = 1; mux_sel = 1; wait_n(4);
    cs_n = 0;
    mx_cycle(1, 1, 8'h22, 8'h5A, 8'h00, 1);
    mx_cycle(1, 0, 8'h22, 8'h00, 8'h5A, 1);
    mx_cycle(0, 1, 8'h33, 8'hC3, 8'h00, 1);
    mx_cycle(0, 0, 8'h33, 8'h00, 8'hC3, 1);
    mx_cycle(1, 0, 8'h33, 8'h00, 8'hC3, 1);
    mx_cycle(0, 0, 8'h22, 8'h00, 8'h5A, 1);
    chk(mem[8'h22] === 8'h5A, "R4 split-strobe write", 32'(mem[8'h22]), 32'h5A);
    chk(mem[8'h33] === 8'hC3, "R4 qualified-strobe write", 32'(mem[8'h33]), 32'hC3);

    // R8: strobes while the latch line is high
    p0 = n_re + n_we;
    alat = 1; wait_n(4);
    strb = 0; wait_n(5); strb = 1; wait_n(5); dirn = 0; wait_n(5); dirn = 1; wait_n(5);
    chk(n_re + n_we == p0, "R8 no pulse while latch high", 32'(n_re + n_we - p0), 0);
    alat = 0; strb = 1; wait_n(5);

    // R8: full shared transfer without chip select
    cs_n = 1; wait_n(4);
    mx_cycle(1, 1, 8'h22, 8'hEE, 8'h00, 0);
    chk(mem[8'h22] === 8'h5A, "R8 write ignored without cs", 32'(mem[8'h22]), 32'h5A);

    wait_n(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule